// File: doc/BRIEF.md
# Compact integer execute stage

This block is the execute step of a small 32-bit integer core that has no register windows. Decode has already split the instruction into its opcode fields (`op0`, `op1`, `op2`) and its three 4-bit register fields (`r`, `s`, `t`). The register file has already been read, so the values of registers `s` and `t` arrive as operands. The stage computes one result. It also chooses the destination register index and decides whether the instruction writes back or is flagged as illegal. All of these leave through one output register stage.

Two instruction groups are handled. The first is the 3-byte register-register group (`op0 = 0`, `op1 = 0`): bitwise logic, negate, absolute value, add and subtract, and add and subtract with the `s` operand scaled by 2, 4 or 8. The second is the 2-byte compact group: add, add with a small immediate, move of a small immediate, and register move. The 2-byte forms exist only when the compact-encoding option is enabled. Every other encoding reaches the output as an illegal instruction with no write.

Top module: `int_exec_stage`

## Requirements
- R1: With `op0=0`, `op1=0`, `op2` codes 1, 2 and 3 write `s AND t`, `s OR t` and `s XOR t` to register index `r`.
- R2: With `op2=6`, `s` field 0 writes `0 - t` to `r`. `s` field 1 writes the absolute value of `t`. A non-negative `t` passes through unchanged, and `0x80000000` maps to itself. Any other `s` field is illegal.
- R3: `op2=8` writes `s + t` to `r`. `op2` codes 9, 10 and 11 write `(s << (op2-8)) + t`. Bits shifted out and the carry out are lost.
- R4: `op2=12` writes `s - t` to `r`. `op2` codes 13, 14 and 15 write `(s << (op2-12)) - t`, modulo 2^32.
- R5: `op0=10` (compact add) writes `s + t` to `r`.
- R6: `op0=11` (compact add-immediate) writes `s + imm` to `r`. `imm` is the 4-bit `t` field taken as an unsigned value, except that `t=0` means -1.
- R7: `op0=12` with `t[3]=0` writes to register index `s` the value whose bits 6:0 are `{t[2:0], r}`. Bits 31:7 are all ones when `t[2:1]=2'b11` and all zeros otherwise.
- R8: `op0=13` with `r=0` copies the `s` operand to register index `t`.
- R9: Any encoding with `op0` of 8 or more is illegal and does not write while `dense_en_i` is low.
- R10: These encodings raise `illegal_o` and keep `wr_en_o` low: `op0` 1 to 7; `op0=0` with `op1` not 0; `op2` 0, 4, 5 or 7; `op0` 8, 9, 14 or 15; `op0=12` with `t[3]=1`; `op0=13` with `r` not 0.
- R11: All outputs change one clock after the inputs are presented. `valid_o` follows `valid_i`. `wr_en_o` and `illegal_o` are low whenever `valid_o` is low. Reset clears `valid_o`, `wr_en_o` and `illegal_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Decoded instruction present this cycle |
| dense_en_i | input | 1 | Compact 2-byte encodings enabled |
| op0_i | input | 4 | Major opcode field |
| op1_i | input | 4 | Second opcode field |
| op2_i | input | 4 | Third opcode field |
| r_i | input | 4 | `r` register field |
| s_i | input | 4 | `s` register field |
| t_i | input | 4 | `t` register field |
| src_s_i | input | XLEN | Value of register `s` |
| src_t_i | input | XLEN | Value of register `t` |
| valid_o | output | 1 | Registered result slot valid |
| wr_en_o | output | 1 | Write `result_o` to `dest_o` |
| illegal_o | output | 1 | Instruction is not executable here |
| dest_o | output | 4 | Destination register index |
| result_o | output | XLEN | Computed result |

## Verification
The bench builds the stage with the default `XLEN` of 32, so the edge cases are those of 32-bit words. They include the wrap of `0xFFFFFFFF + 1`, negation and absolute value of `0x80000000`, and scaled operands whose top bits shift out of the word. At this width the small immediates are exercised at every sign-extension boundary, `0x5F`/`0xFFFFFFE0` for the move-immediate and the `t=0` case for the add-immediate. Directed encodings cover every reserved code, then several thousand randomly drawn encodings follow, biased toward the two implemented groups and with the compact-encoding enable toggling.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  typedef logic [3:0] fld_t;

  localparam fld_t OP0_RRR  = 4'd0;
  localparam fld_t OP0_NADD = 4'd10;
  localparam fld_t OP0_NADI = 4'd11;
  localparam fld_t OP0_NMVI = 4'd12;
  localparam fld_t OP0_NMOV = 4'd13;

  localparam fld_t OP2_AND  = 4'd1;
  localparam fld_t OP2_OR   = 4'd2;
  localparam fld_t OP2_XOR  = 4'd3;
  localparam fld_t OP2_NEGA = 4'd6;

  localparam int   NSCALE   = 4;
endpackage

// File: rtl/iex_wide_ops.sv
module iex_wide_ops
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fld_t            op2_i,
  input  fld_t            s_fld_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] res_o,
  output logic            ok_o
);
  logic [XLEN-1:0] add_v [NSCALE];
  logic [XLEN-1:0] sub_v [NSCALE];
  logic [XLEN-1:0] neg_b;

  for (genvar k = 0; k < NSCALE; k++) begin : g_scale
    assign add_v[k] = (opa_i << k) + opb_i;
    assign sub_v[k] = (opa_i << k) - opb_i;
  end

  assign neg_b = '0 - opb_i;

  always_comb begin
    res_o = '0;
    ok_o  = 1'b1;
    case (op2_i)
      OP2_AND:  res_o = opa_i & opb_i;
      OP2_OR:   res_o = opa_i | opb_i;
      OP2_XOR:  res_o = opa_i ^ opb_i;
      OP2_NEGA: begin
        if (s_fld_i == 4'd0)      res_o = neg_b;
        else if (s_fld_i == 4'd1) res_o = opb_i[XLEN-1] ? neg_b : opb_i;
        else                      ok_o  = 1'b0;
      end
      4'd8, 4'd9, 4'd10, 4'd11:   res_o = add_v[op2_i[1:0]];
      4'd12, 4'd13, 4'd14, 4'd15: res_o = sub_v[op2_i[1:0]];
      default:  ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/iex_narrow_ops.sv
module iex_narrow_ops
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fld_t            op0_i,
  input  fld_t            r_i,
  input  fld_t            s_i,
  input  fld_t            t_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] res_o,
  output fld_t            dest_o,
  output logic            ok_o
);
  localparam int MVI_W = 7;

  logic [XLEN-1:0] addi_imm;
  logic [XLEN-1:0] mvi_val;
  logic            mvi_neg;

  // t==0 encodes -1
  assign addi_imm = (t_i == 4'd0) ? '1 : XLEN'(t_i);
  assign mvi_neg  = (t_i[2:1] == 2'b11);
  assign mvi_val  = {{(XLEN-MVI_W){mvi_neg}}, t_i[2:0], r_i};

  always_comb begin
    res_o  = '0;
    dest_o = r_i;
    ok_o   = 1'b1;
    case (op0_i)
      OP0_NADD: res_o = opa_i + opb_i;
      OP0_NADI: res_o = opa_i + addi_imm;
      OP0_NMVI: begin
        dest_o = s_i;
        res_o  = mvi_val;
        ok_o   = !t_i[3];
      end
      OP0_NMOV: begin
        dest_o = t_i;
        res_o  = opa_i;
        ok_o   = (r_i == 4'd0);
      end
      default:  ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            dense_en_i,
  input  logic [3:0]      op0_i,
  input  logic [3:0]      op1_i,
  input  logic [3:0]      op2_i,
  input  logic [3:0]      r_i,
  input  logic [3:0]      s_i,
  input  logic [3:0]      t_i,
  input  logic [XLEN-1:0] src_s_i,
  input  logic [XLEN-1:0] src_t_i,
  output logic            valid_o,
  output logic            wr_en_o,
  output logic            illegal_o,
  output logic [3:0]      dest_o,
  output logic [XLEN-1:0] result_o
);
  logic [XLEN-1:0] w_res, n_res, nxt_res;
  logic            w_ok, n_ok, nxt_ok;
  fld_t            n_dest, nxt_dest;
  logic            is_wide, is_narrow;

  iex_wide_ops #(.XLEN(XLEN)) u_wide (
    .op2_i   (op2_i),
    .s_fld_i (s_i),
    .opa_i   (src_s_i),
    .opb_i   (src_t_i),
    .res_o   (w_res),
    .ok_o    (w_ok)
  );

  iex_narrow_ops #(.XLEN(XLEN)) u_narrow (
    .op0_i  (op0_i),
    .r_i    (r_i),
    .s_i    (s_i),
    .t_i    (t_i),
    .opa_i  (src_s_i),
    .opb_i  (src_t_i),
    .res_o  (n_res),
    .dest_o (n_dest),
    .ok_o   (n_ok)
  );

  assign is_wide   = (op0_i == OP0_RRR) && (op1_i == 4'd0);
  assign is_narrow = op0_i[3];

  always_comb begin
    nxt_res  = '0;
    nxt_dest = r_i;
    nxt_ok   = 1'b0;
    if (is_wide) begin
      nxt_res = w_res;
      nxt_ok  = w_ok;
    end else if (is_narrow) begin
      nxt_res  = n_res;
      nxt_dest = n_dest;
      nxt_ok   = dense_en_i && n_ok;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      dest_o    <= '0;
      result_o  <= '0;
    end else begin
      valid_o   <= valid_i;
      wr_en_o   <= valid_i && nxt_ok;
      illegal_o <= valid_i && !nxt_ok;
      dest_o    <= nxt_dest;
      result_o  <= nxt_res;
    end
  end

  assert_and_path_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op0_i == 4'd0 && op1_i == 4'd0 && op2_i == 4'd1
    |=> wr_en_o && dest_o == $past(r_i) && result_o == ($past(src_s_i) & $past(src_t_i)));

  assert_mvi_dest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dense_en_i && op0_i == 4'd12 && !t_i[3]
    |=> wr_en_o && dest_o == $past(s_i));

  assert_mov_copy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dense_en_i && op0_i == 4'd13 && r_i == 4'd0
    |=> wr_en_o && dest_o == $past(t_i) && result_o == $past(src_s_i));

  assert_dense_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op0_i[3] && !dense_en_i |=> illegal_o && !wr_en_o);

  assert_reserved_op0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op0_i != 4'd0 && !op0_i[3] |=> illegal_o && !wr_en_o);

  assert_valid_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !wr_en_o && !illegal_o);
endmodule

// File: tb/int_exec_stage_tb_top.sv
module int_exec_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, dense_en_i = 1'b1;
  logic [3:0]  op0_i = '0, op1_i = '0, op2_i = '0, r_i = '0, s_i = '0, t_i = '0;
  logic [31:0] src_s_i = '0, src_t_i = '0;
  logic        valid_o, wr_en_o, illegal_o;
  logic [3:0]  dest_o;
  logic [31:0] result_o;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  bit          pend = 0;
  bit          e_v, e_wr, e_ill;
  bit [3:0]    e_dest;
  bit [31:0]   e_res;
  string       e_tag;

  always #5 clk = ~clk;

  int_exec_stage dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .dense_en_i(dense_en_i),
    .op0_i(op0_i), .op1_i(op1_i), .op2_i(op2_i), .r_i(r_i), .s_i(s_i), .t_i(t_i),
    .src_s_i(src_s_i), .src_t_i(src_t_i), .valid_o(valid_o), .wr_en_o(wr_en_o),
    .illegal_o(illegal_o), .dest_o(dest_o), .result_o(result_o)
  );

  // behavioural reference
  function automatic void model(input bit v, input bit de, input int o0, input int o1,
                                input int o2, input int r, input int s, input int t,
                                input bit [31:0] a, input bit [31:0] b,
                                output bit wr, output bit ill, output bit [3:0] dest,
                                output bit [31:0] res, output string tag);
    bit ok = 1;
    dest = 4'(r); res = 0; tag = "R10";
    if (o0 == 0 && o1 == 0) begin
      if (o2 == 1) begin res = a & b; tag = "R1"; end
      else if (o2 == 2) begin res = a | b; tag = "R1"; end
      else if (o2 == 3) begin res = a ^ b; tag = "R1"; end
      else if (o2 == 6) begin
        tag = "R2";
        if (s == 0) res = 32'(0 - longint'(b));
        else if (s == 1) res = ($signed(b) < 0) ? 32'(0 - longint'(b)) : b;
        else ok = 0;
      end else if (o2 >= 8 && o2 <= 11) begin
        res = 32'(longint'(a) * (64'd1 << (o2 - 8)) + longint'(b)); tag = "R3";
      end else if (o2 >= 12) begin
        res = 32'(longint'(a) * (64'd1 << (o2 - 12)) - longint'(b)); tag = "R4";
      end else ok = 0;
    end else if (o0 >= 8) begin
      if (o0 == 10) begin res = a + b; tag = "R5"; end
      else if (o0 == 11) begin res = a + ((t == 0) ? 32'hFFFF_FFFF : 32'(t)); tag = "R6"; end
      else if (o0 == 12 && t < 8) begin
        int val = (t % 8) * 16 + r;
        if ((t % 8) >= 6) val = val - 128;
        res = 32'(val); dest = 4'(s); tag = "R7";
      end else if (o0 == 13 && r == 0) begin res = a; dest = 4'(t); tag = "R8"; end
      else ok = 0;
      if (!de) begin ok = 0; tag = "R9"; end
    end else ok = 0;
    if (!v) begin ok = 1; tag = "R11"; end
    wr = v && ok; ill = v && !ok;
  endfunction

  task automatic check_out();
    bit bad;
    if (!pend) return;
    compared++;
    bad = (valid_o !== e_v) || (wr_en_o !== e_wr) || (illegal_o !== e_ill) ||
          (e_wr && ((dest_o !== e_dest) || (result_o !== e_res)));
    if (bad) begin
      mismatched++;
      $display("FAIL %s: actual v=%b wr=%b ill=%b dest=%0d res=%h expected v=%b wr=%b ill=%b dest=%0d res=%h",
               e_tag, valid_o, wr_en_o, illegal_o, dest_o, result_o,
               e_v, e_wr, e_ill, e_dest, e_res);
    end
  endtask

  task automatic drive(input bit v, input bit de, input int o0, input int o1, input int o2,
                       input int r, input int s, input int t,
                       input bit [31:0] a, input bit [31:0] b);
    @(negedge clk);
    check_out();
    valid_i = v; dense_en_i = de;
    op0_i = 4'(o0); op1_i = 4'(o1); op2_i = 4'(o2);
    r_i = 4'(r); s_i = 4'(s); t_i = 4'(t);
    src_s_i = a; src_t_i = b;
    e_v = v;
    model(v, de, o0, o1, o2, r, s, t, a, b, e_wr, e_ill, e_dest, e_res, e_tag);
    pend = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R11: watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    compared++;
    if (valid_o !== 1'b0 || wr_en_o !== 1'b0 || illegal_o !== 1'b0) begin
      mismatched++;
      $display("FAIL R11: reset actual v=%b wr=%b ill=%b expected 0 0 0", valid_o, wr_en_o, illegal_o);
    end
    rst_n = 1'b1;

    // R1
    drive(1, 1, 0, 0, 1, 3, 4, 5, 32'hF0F0_1234, 32'h0FF0_FF00);
    drive(1, 1, 0, 0, 2, 7, 4, 5, 32'hF0F0_1234, 32'h0FF0_FF00);
    drive(1, 1, 0, 0, 3, 15, 4, 5, 32'hF0F0_1234, 32'h0FF0_FF00);
    // R2
    drive(1, 1, 0, 0, 6, 2, 0, 9, 0, 32'd0);
    drive(1, 1, 0, 0, 6, 2, 0, 9, 0, 32'h8000_0000);
    drive(1, 1, 0, 0, 6, 2, 1, 9, 0, 32'hFFFF_FFFB);
    drive(1, 1, 0, 0, 6, 2, 1, 9, 0, 32'd7);
    drive(1, 1, 0, 0, 6, 2, 1, 9, 0, 32'h8000_0000);
    drive(1, 1, 0, 0, 6, 2, 2, 9, 0, 32'd7);
    // R3
    drive(1, 1, 0, 0, 8, 1, 2, 3, 32'hFFFF_FFFF, 32'd1);
    drive(1, 1, 0, 0, 9, 1, 2, 3, 32'h8000_0003, 32'd5);
    drive(1, 1, 0, 0, 11, 1, 2, 3, 32'h2000_0001, 32'd10);
    // R4
    drive(1, 1, 0, 0, 12, 6, 2, 3, 32'd3, 32'd5);
    drive(1, 1, 0, 0, 13, 6, 2, 3, 32'd100, 32'd1);
    drive(1, 1, 0, 0, 15, 6, 2, 3, 32'hF000_0001, 32'd9);
    // R5 / R6
    drive(1, 1, 10, 0, 0, 4, 1, 2, 32'hFFFF_FFFE, 32'd3);
    drive(1, 1, 11, 0, 0, 4, 1, 0, 32'd0, 32'd77);
    drive(1, 1, 11, 0, 0, 4, 1, 15, 32'd10, 32'd77);
    // R7
    drive(1, 1, 12, 0, 0, 15, 6, 3, 0, 0);
    drive(1, 1, 12, 0, 0, 15, 6, 5, 0, 0);
    drive(1, 1, 12, 0, 0, 0, 9, 6, 0, 0);
    drive(1, 1, 12, 0, 0, 15, 9, 7, 0, 0);
    // R8
    drive(1, 1, 13, 0, 0, 0, 3, 11, 32'hCAFE_BABE, 32'd1);
    // R9
    drive(1, 0, 10, 0, 0, 4, 1, 2, 32'd1, 32'd2);
    drive(1, 0, 12, 0, 0, 1, 1, 2, 32'd1, 32'd2);
    // R10
    drive(1, 1, 13, 0, 0, 1, 3, 11, 32'd1, 32'd2);
    drive(1, 1, 12, 0, 0, 1, 3, 8, 32'd1, 32'd2);
    drive(1, 1, 3, 0, 8, 1, 3, 8, 32'd1, 32'd2);
    drive(1, 1, 0, 2, 8, 1, 3, 8, 32'd1, 32'd2);
    drive(1, 1, 8, 0, 0, 1, 3, 4, 32'd1, 32'd2);
    drive(1, 1, 15, 0, 0, 1, 3, 4, 32'd1, 32'd2);
    for (int k = 0; k < 8; k++)
      if (k == 0 || k == 4 || k == 5 || k == 7) drive(1, 1, 0, 0, k, 1, 3, 4, 32'd1, 32'd2);
    // R11 idle slots
    drive(0, 1, 0, 0, 8, 1, 2, 3, 32'd1, 32'd2);
    drive(0, 1, 3, 0, 0, 1, 2, 3, 32'd1, 32'd2);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int sel = int'($urandom_range(0, 9));
      int o0  = (sel < 5) ? 0 : ((sel < 9) ? int'($urandom_range(8, 15)) : int'($urandom_range(0, 7)));
      int o1  = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 15)) : 0;
      drive(($urandom_range(0, 7) != 0), ($urandom_range(0, 9) != 0), o0, o1,
            int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
            ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 2)) : int'($urandom_range(0, 15)),
            int'($urandom_range(0, 15)), $urandom, $urandom);
    end

    // R11 async reset clears a live slot
    drive(1, 1, 0, 0, 8, 1, 2, 3, 32'd1, 32'd2);
    @(negedge clk);
    check_out();
    pend = 0;
    valid_i = 1'b1;
    #2 rst_n = 1'b0;
    #1;
    compared++;
    if (valid_o !== 1'b0 || wr_en_o !== 1'b0 || illegal_o !== 1'b0) begin
      mismatched++;
      $display("FAIL R11: mid-run reset actual v=%b wr=%b ill=%b expected 0 0 0", valid_o, wr_en_o, illegal_o);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule